// File: doc/BRIEF.md
# Host-Driven Passive-Serial Configuration Loader

This block sits between a byte-wide host register bus and the configuration pins of an SRAM-based FPGA. The host issues a start command through a control bit. The block then drives the device's configuration-request line low and waits for the device's status line to go low and come back high. When that handshake completes, the block raises a ready flag that the host polls. The host then writes the bitstream one byte per bus write. Each byte is shifted out least significant bit first on a serial data pin, with one rising edge of a configuration clock per bit.

The block reports the device status and done lines in its control/status register. It shows a fixed identification byte whose value tells the host which mode is active. When the done line rises after the last byte, bus ownership passes automatically to the user-mode logic. From then on, every offset except the identification byte is forwarded to a user-logic port. A host write of 1 to control bit 0 still restarts configuration from user mode. If the status line drops during loading, or if the ready handshake does not finish within a parameterised window, the loader latches an error and returns to idle configuration mode.

Top module: `cfg_loader`

## Requirements
- R1: After reset the block is in configuration mode: cfg_en is 1, dev_ncfg is 1, dev_dclk is 0, and status bits 0 (ready), 3 (error) and 4 (busy) are 0.
- R2: A read at offset 0x0A returns 0x48 in configuration mode and 0x49 in user mode. This offset is never forwarded to the user port.
- R3: A write at offset 0x00 with data bit 0 set clears the error bit and starts a cycle. dev_ncfg is driven low in the cycle after the write, for exactly NCFG_LOW cycles.
- R4: Status bit 0 (ready) reads 1 only after the synchronised dev_nstatus has been seen low and then high since the start command. It stays 1 while loading continues.
- R5: If ready is not reached within TIMEOUT cycles after dev_ncfg is released, the error bit (status bit 3) is set and the block returns to idle with ready at 0.
- R6: Status bit 1 shows dev_nstatus and status bit 2 shows dev_conf_done, each delayed by SYNC_STAGES clock cycles. Status bit 4 shows the serialiser busy flag. Bits 7:5 read 0.
- R7: A write at offset 0x02 while ready and not busy loads the byte. In the cycle after the write, dev_data0 carries bit 0 and dev_dclk is low. The clock then goes high one cycle later and alternates each cycle, giving eight rising edges. Bits are presented in ascending order, each bit held for one low and one high cycle. Busy clears 17 cycles after the write.
- R8: A write at offset 0x02 while busy or while not ready is ignored: it produces no dev_dclk edge and does not change the serial stream.
- R9: If dev_nstatus is seen low while loading, the block clears ready, sets the error bit and returns to idle configuration mode.
- R10: When dev_conf_done is seen high while loading and the serialiser is idle, the block enters user mode. cfg_en falls to 0. Every access at an offset other than 0x0A asserts usr_sel, its read data comes from usr_rdata, and dev_dclk stays low.
- R11: In user mode, a write at offset 0x00 with bit 0 set is forwarded to the user port and also restarts configuration. After that write, cfg_en is 1 and dev_ncfg is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid combinationally during the access |
| cfg_en | output | 1 | High while in configuration mode |
| usr_sel | output | 1 | Forwarded access strobe to the user logic |
| usr_wr | output | 1 | Forwarded write flag |
| usr_addr | output | ADDR_W | Forwarded offset |
| usr_wdata | output | 8 | Forwarded write data |
| usr_rdata | input | 8 | Read data from the user logic |
| dev_ncfg | output | 1 | Active-low configuration request to the device |
| dev_nstatus | input | 1 | Device status line, low on reset or error |
| dev_conf_done | input | 1 | Device done line |
| dev_dclk | output | 1 | Serial configuration clock |
| dev_data0 | output | 1 | Serial configuration data |

## Verification
Register reads are combinational, so the bench samples read data one time step after it drives the address. It samples the forwarded user strobe in the same step. The serial stream begins in the cycle after the accepted write. The bench queues seventeen expected clock/data pairs per accepted byte and compares one pair on every falling edge. When no pairs are queued, it requires the clock to stay low, which covers ignored writes. Status mirrors, aborts and the change to user mode lag the device pins by the two synchroniser stages plus one state register. The bench therefore waits three or four cycles before it reads them. The configuration-request pulse is counted sample by sample from the cycle after the start write.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_LOAD,
        ST_USER
    } seq_st_e;

    localparam logic [7:0] ID_CFG_MODE = 8'h48;
    localparam logic [7:0] ID_USR_MODE = 8'h49;

    localparam int OFF_CTRL = 'h0;
    localparam int OFF_DATA = 'h2;
    localparam int OFF_ID   = 'hA;

    localparam int STAT_READY = 0;
    localparam int STAT_NSTAT = 1;
    localparam int STAT_DONE  = 2;
    localparam int STAT_ERR   = 3;
    localparam int STAT_BUSY  = 4;

endpackage

// File: rtl/cfg_loader_sync.sv
module cfg_loader_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_loader_ser.sv
module cfg_loader_ser #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          abort,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic          dclk,
    output logic          dout
);
    localparam int PHASES = 2 * DW;
    localparam int CW     = $clog2(PHASES);
    localparam logic [CW-1:0] LAST = CW'(PHASES - 1);

    typedef struct packed {
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          dclk;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.dclk = 1'b0;
            s_d.cnt  = '0;
        end else if (load && !s_q.busy) begin
            s_d.sh   = din;
            s_d.cnt  = '0;
            s_d.busy = 1'b1;
            s_d.dclk = 1'b0;
        end else if (s_q.busy) begin
            if (!s_q.cnt[0]) begin
                s_d.dclk = 1'b1;
                s_d.cnt  = s_q.cnt + 1'b1;
            end else if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.dclk = 1'b0;
            end else begin
                s_d.dclk = 1'b0;
                s_d.sh   = s_q.sh >> 1;
                s_d.cnt  = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sh: '0, cnt: '0, busy: 1'b0, dclk: 1'b0};
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign dclk = s_q.dclk;
    assign dout = s_q.sh[0];
endmodule

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
    import cfg_loader_pkg::*;
#(
    parameter int NCFG_LOW = 8,
    parameter int TIMEOUT  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ns_s,
    input  logic cd_s,
    input  logic ser_busy,
    output logic ncfg,
    output logic ready,
    output logic err,
    output logic user,
    output logic ser_abort
);
    localparam int MAXC = (NCFG_LOW > TIMEOUT) ? NCFG_LOW : TIMEOUT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_END = CW'(NCFG_LOW - 1);
    localparam logic [CW-1:0] WAIT_END  = CW'(TIMEOUT - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          err;
        logic          ncfg;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        ser_abort = 1'b0;
        unique case (s_q.st)
            ST_IDLE: ;
            ST_PULSE: begin
                if (!ns_s) s_d.seen = 1'b1;
                if (s_q.cnt == PULSE_END) begin
                    s_d.ncfg = 1'b1;
                    s_d.st   = ST_WAIT;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (!ns_s) s_d.seen = 1'b1;
                if (s_q.seen && ns_s) begin
                    s_d.st = ST_LOAD;
                end else if (s_q.cnt == WAIT_END) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                if (!ns_s) begin
                    s_d.err   = 1'b1;
                    s_d.st    = ST_IDLE;
                    ser_abort = 1'b1;
                end else if (cd_s && !ser_busy) begin
                    s_d.st = ST_USER;
                end
            end
            ST_USER: ;
            default: s_d.st = ST_IDLE;
        endcase
        if (start) begin
            s_d.st    = ST_PULSE;
            s_d.ncfg  = 1'b0;
            s_d.cnt   = '0;
            s_d.seen  = 1'b0;
            s_d.err   = 1'b0;
            ser_abort = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, seen: 1'b0, err: 1'b0, ncfg: 1'b1};
        else        s_q <= s_d;
    end

    assign ncfg  = s_q.ncfg;
    assign err   = s_q.err;
    assign ready = (s_q.st == ST_LOAD);
    assign user  = (s_q.st == ST_USER);
endmodule

// File: rtl/cfg_loader_regs.sv
module cfg_loader_regs
    import cfg_loader_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              user,
    input  logic              ready,
    input  logic              err,
    input  logic              busy,
    input  logic              ns_s,
    input  logic              cd_s,
    input  logic [7:0]        usr_rdata,
    output logic              start,
    output logic              data_load,
    output logic              usr_sel,
    output logic              usr_wr,
    output logic [ADDR_W-1:0] usr_addr,
    output logic [7:0]        usr_wdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFF_ID);

    logic       is_id;
    logic [7:0] status;

    always_comb begin
        is_id = (bus_addr == A_ID);

        status              = '0;
        status[STAT_READY]  = ready;
        status[STAT_NSTAT]  = ns_s;
        status[STAT_DONE]   = cd_s;
        status[STAT_ERR]    = err;
        status[STAT_BUSY]   = busy;

        start     = bus_sel && bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
        data_load = bus_sel && bus_wr && !user && (bus_addr == A_DATA) && ready && !busy;

        usr_sel   = bus_sel && user && !is_id;
        usr_wr    = bus_wr;
        usr_addr  = bus_addr;
        usr_wdata = bus_wdata;

        if (is_id)                   bus_rdata = user ? ID_USR_MODE : ID_CFG_MODE;
        else if (user)               bus_rdata = usr_rdata;
        else if (bus_addr == A_CTRL) bus_rdata = status;
        else                         bus_rdata = '0;
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int ADDR_W      = 4,
    parameter int NCFG_LOW    = 8,
    parameter int TIMEOUT     = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_en,
    output logic              usr_sel,
    output logic              usr_wr,
    output logic [ADDR_W-1:0] usr_addr,
    output logic [7:0]        usr_wdata,
    input  logic [7:0]        usr_rdata,
    output logic              dev_ncfg,
    input  logic              dev_nstatus,
    input  logic              dev_conf_done,
    output logic              dev_dclk,
    output logic              dev_data0
);
    logic ns_s, cd_s;
    logic seq_ready, seq_err, seq_user, ser_abort;
    logic ser_busy, start, data_load;

    cfg_loader_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ns (
        .clk(clk), .rst_n(rst_n), .d(dev_nstatus), .q(ns_s)
    );

    cfg_loader_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cd (
        .clk(clk), .rst_n(rst_n), .d(dev_conf_done), .q(cd_s)
    );

    cfg_loader_regs #(.ADDR_W(ADDR_W)) u_regs (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .user(seq_user), .ready(seq_ready), .err(seq_err), .busy(ser_busy),
        .ns_s(ns_s), .cd_s(cd_s), .usr_rdata(usr_rdata),
        .start(start), .data_load(data_load),
        .usr_sel(usr_sel), .usr_wr(usr_wr), .usr_addr(usr_addr), .usr_wdata(usr_wdata)
    );

    cfg_loader_seq #(.NCFG_LOW(NCFG_LOW), .TIMEOUT(TIMEOUT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ns_s(ns_s), .cd_s(cd_s),
        .ser_busy(ser_busy), .ncfg(dev_ncfg), .ready(seq_ready), .err(seq_err),
        .user(seq_user), .ser_abort(ser_abort)
    );

    cfg_loader_ser #(.DW(8)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(data_load), .abort(ser_abort),
        .din(bus_wdata), .busy(ser_busy), .dclk(dev_dclk), .dout(dev_data0)
    );

    assign cfg_en = !seq_user;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              dev_ncfg,
    input logic              dev_dclk,
    input logic              usr_sel,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              ready,
    input logic              err,
    input logic              ser_busy
);
    localparam logic [ADDR_W-1:0] A_ID = ADDR_W'('hA);

    AST_USER_NCFG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> dev_ncfg); // R10
    AST_DCLK_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dclk |-> (ser_busy && ready)); // R7
    AST_DCLK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dclk |=> !dev_dclk); // R7
    AST_NO_FORWARD_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        usr_sel |-> (!cfg_en && bus_addr != A_ID)); // R10
    AST_ID_BYTE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_ID) |-> (bus_rdata == (cfg_en ? 8'h48 : 8'h49))); // R2
    AST_ERR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !ready); // R9
    AST_USER_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |-> $past(ready)); // R10
endmodule

bind cfg_loader cfg_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .dev_ncfg(dev_ncfg),
    .dev_dclk(dev_dclk), .usr_sel(usr_sel), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ready(seq_ready),
    .err(seq_err), .ser_busy(ser_busy)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
    localparam int ADDR_W   = 4;
    localparam int NCFG_LOW = 8;
    localparam int TIMEOUT  = 400;
    localparam int WD_CYC   = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              cfg_en, usr_sel, usr_wr;
    logic [ADDR_W-1:0] usr_addr;
    logic [7:0]        usr_wdata;
    logic [7:0]        usr_rdata = 8'h5A;
    logic              dev_ncfg, dev_dclk, dev_data0;
    logic              dev_nstatus = 1'b1, dev_conf_done = 1'b0;

    int   n_checks = 0, n_fails = 0;
    bit   mon_on = 1'b0, done = 1'b0;
    logic last_usr_sel;
    logic [1:0] exp_q[$];

    always #5 clk = ~clk;

    cfg_loader #(.ADDR_W(ADDR_W), .NCFG_LOW(NCFG_LOW), .TIMEOUT(TIMEOUT), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_en(cfg_en), .usr_sel(usr_sel),
        .usr_wr(usr_wr), .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .dev_ncfg(dev_ncfg), .dev_nstatus(dev_nstatus), .dev_conf_done(dev_conf_done),
        .dev_dclk(dev_dclk), .dev_data0(dev_data0)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Serial reference: one expected {dclk,data0} pair per clock
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check("R7 serial pair", {dev_dclk, dev_data0}, e);
            end else begin
                check("R8 clock idle", dev_dclk, 0);
            end
        end
    end

    task automatic bus_write(input int addr, input logic [7:0] d, input bit accept);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = d;
        if (accept) begin
            for (int i = 0; i < 8; i++) begin
                exp_q.push_back({1'b0, d[i]});
                exp_q.push_back({1'b1, d[i]});
            end
            exp_q.push_back({1'b0, d[7]});
        end
        #1 last_usr_sel = usr_sel;
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [7:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
        #1 d = bus_rdata; last_usr_sel = usr_sel;
        bus_sel = 1'b0;
    endtask

    task automatic wait_serial_idle();
        do begin @(negedge clk); #1; end while (exp_q.size() != 0);
    endtask

    task automatic start_to_ready();
        logic [7:0] v;
        int lows = 0;
        dev_conf_done = 1'b0;
        bus_write(0, 8'h01, 0);
        dev_nstatus = 1'b0;
        for (int i = 0; i < NCFG_LOW + 4; i++) begin
            if (!dev_ncfg) lows++;
            @(negedge clk); #1;
        end
        check("R3 nconfig low cycles", lows, NCFG_LOW);
        repeat (2) @(negedge clk);
        bus_read(0, v);
        check("R4 not ready while status low", v, 8'h00);
        dev_nstatus = 1'b1;
        for (int i = 0; i < 20; i++) begin
            bus_read(0, v);
            if (v[0]) break;
        end
        check("R4 ready after low-high", v, 8'h03);
    endtask

    initial begin
        logic [7:0] v;
        last_usr_sel = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk); #1;

        check("R1 cfg_en", cfg_en, 1);
        check("R1 ncfg", dev_ncfg, 1);
        check("R1 dclk", dev_dclk, 0);
        bus_read(0, v);
        check("R1 status", v, 8'h02);
        bus_read('hA, v);
        check("R2 id in config", v, 8'h48);

        bus_write(2, 8'hFF, 0); // R8 not ready: no serial activity
        repeat (20) @(negedge clk);

        dev_nstatus = 1'b0; dev_conf_done = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(0, v);
        check("R6 mirror low/high", v, 8'h04);
        dev_nstatus = 1'b1; dev_conf_done = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(0, v);
        check("R6 mirror high/low", v, 8'h02);

        start_to_ready();

        bus_write(2, 8'hA5, 1);
        bus_read(0, v);
        check("R6 busy bit", v, 8'h13);
        bus_write(2, 8'hFF, 0); // R8 busy: ignored
        wait_serial_idle();
        bus_write(2, 8'h3C, 1);
        wait_serial_idle();
        bus_write(2, 8'h01, 1);
        wait_serial_idle();
        repeat (2) @(negedge clk);

        dev_nstatus = 1'b0; // R9 abort
        repeat (4) @(negedge clk);
        bus_read(0, v);
        check("R9 abort status", v, 8'h08);
        check("R9 stays config", cfg_en, 1);
        dev_nstatus = 1'b1;
        repeat (3) @(negedge clk);

        start_to_ready(); // R3 restart clears error

        bus_write(0, 8'h01, 0); // R5 timeout, status never low
        repeat (NCFG_LOW + TIMEOUT / 2) @(negedge clk);
        bus_read(0, v);
        check("R5 not ready mid-window", v, 8'h02);
        repeat (TIMEOUT) @(negedge clk);
        bus_read(0, v);
        check("R5 timeout error", v, 8'h0A);

        start_to_ready();
        bus_write(2, 8'h96, 1);
        wait_serial_idle();
        dev_conf_done = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 cfg_en low", cfg_en, 0);
        bus_read('hA, v);
        check("R2 id in user", v, 8'h49);
        check("R2 id not forwarded", last_usr_sel, 0);
        bus_read(0, v);
        check("R10 read routed", v, 8'h5A);
        check("R10 read strobe", last_usr_sel, 1);
        bus_write(2, 8'hC3, 0);
        check("R10 write strobe", last_usr_sel, 1);
        check("R10 write data", usr_wdata, 8'hC3);
        repeat (20) @(negedge clk);

        bus_write(0, 8'h01, 0);
        dev_conf_done = 1'b0;
        check("R11 forwarded", last_usr_sel, 1);
        check("R11 cfg_en back", cfg_en, 1);
        check("R11 ncfg low", dev_ncfg, 0);
        bus_read('hA, v);
        check("R11 id config", v, 8'h48);
        repeat (NCFG_LOW + 4) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule